// File: doc/BRIEF.md
# Receive Frame Alignment Padder

This block sits in an Ethernet receive byte stream, between the MAC receive logic and a 32-bit buffer writer. It packs incoming bytes into little-endian words with byte enables. When its alignment enable is set, every frame starts at byte lane 2 of its first word, and lanes 0 and 1 hold two filler bytes. After the 14-byte header, the payload of each frame then starts on a 4-byte boundary in the receive buffer. The filler only lands where intended if each receive buffer starts on a 4-byte address and has a length that is a multiple of 4.

At the end of each frame the block reports the message length, which counts only the bytes actually received and never the filler. The enable is a one-bit register. It can be read and written at any time, and both the hardware reset and the software reset clear it. The stop command leaves it unchanged. Software reset and stop also throw away any frame that is partly packed. The enable value is taken when the first byte of a frame arrives and holds for the whole of that frame.

Top module: `frame_align_padder`

## Requirements
- R1: `cfg_rdata` always shows the enable bit. A write through `cfg_we`/`cfg_wdata` updates it one cycle later, and the hardware reset (`rst_n` low) clears it to 0.
- R2: A `sw_reset` pulse clears the enable bit. A `stop_cmd` pulse leaves it unchanged.
- R3: With the enable set at a frame's first byte, that byte goes to lane 2 (bits [23:16]) of the first output word. Lanes 0 and 1 are filler, and their enables are 1 while their content is undefined.
- R4: With the enable clear at a frame's first byte, no filler is inserted and the first byte goes to lane 0 (bits [7:0]).
- R5: Bytes are packed little-endian: lane k holds bits [8k+7:8k], and later bytes go to higher lanes. A word whose four lanes are all filled comes out with `out_be` = 4'b1111 one cycle after its last byte is accepted, and `out_last` = 0 unless that byte ended the frame.
- R6: The byte flagged `in_eof` flushes the current word one cycle later with `out_last` = 1. Its `out_be` has ones exactly in lanes 0 up to the lane of that byte.
- R7: One cycle after the `in_eof` byte, `len_valid` pulses together with the final word, and `len_bytes` equals the number of received bytes in the frame with the filler excluded.
- R8: A change to the enable only affects frames whose first byte arrives after the write. A write in the same cycle as a frame's first byte, or in the middle of a frame, leaves that frame packed under the previous setting.
- R9: `stop_cmd` or `sw_reset` drops any partly packed frame. No word comes out for it, and the next frame packs from a clean state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_reset | input | 1 | Software reset pulse: clears the enable and drops the partial frame |
| stop_cmd | input | 1 | Stop command: drops the partial frame and keeps the enable |
| cfg_we | input | 1 | Write strobe for the enable bit |
| cfg_wdata | input | 1 | Value written to the enable bit |
| cfg_rdata | output | 1 | Current enable bit |
| in_valid | input | 1 | Received byte valid |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Byte is the first byte of a frame |
| in_eof | input | 1 | Byte is the last byte of a frame |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Packed word, little-endian |
| out_be | output | 4 | Byte enables of the word |
| out_last | output | 1 | Word is the last word of the frame |
| len_valid | output | 1 | Frame length report valid |
| len_bytes | output | 16 | Received byte count of the frame, filler excluded |

## Verification
Two functions can fall in the same cycle: a write to the enable bit, and the latching of the alignment decision on a frame's first byte. The bench provokes this by pulsing `cfg_we` in exactly the cycle it presents a start-of-frame byte, and also halfway through a frame. It then judges the lane of the first byte in that frame and in the frame after it against the old and new settings. A word flush and the length report also share a cycle, so every final word is matched against its length report in the same sample.

// File: rtl/frame_align_padder.sv
module frame_align_padder #(
  parameter int WORD_BYTES = 4,
  parameter int PAD_BYTES  = 2,
  parameter int LEN_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sw_reset,
  input  logic                    stop_cmd,
  input  logic                    cfg_we,
  input  logic                    cfg_wdata,
  output logic                    cfg_rdata,
  input  logic                    in_valid,
  input  logic [7:0]              in_data,
  input  logic                    in_sof,
  input  logic                    in_eof,
  output logic                    out_valid,
  output logic [8*WORD_BYTES-1:0] out_data,
  output logic [WORD_BYTES-1:0]   out_be,
  output logic                    out_last,
  output logic                    len_valid,
  output logic [LEN_W-1:0]        len_bytes
);
  localparam int LANE_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam int DW = 8 * WORD_BYTES;
  localparam logic [LANE_W-1:0] PAD_LANE  = LANE_W'(PAD_BYTES);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(WORD_BYTES - 1);

  logic                  align_en;
  logic [LANE_W-1:0]     lane_q, lane;
  logic [DW-1:0]         word_q, word_nx;
  logic [WORD_BYTES-1:0] be_nx;
  logic [LEN_W-1:0]      cnt_q, cnt_nx;
  logic                  flush, abort;

  assign cfg_rdata = align_en;
  assign abort     = sw_reset | stop_cmd;
  assign lane      = in_sof ? (align_en ? PAD_LANE : '0) : lane_q;
  assign cnt_nx    = in_sof ? LEN_W'(1) : cnt_q + LEN_W'(1);
  assign flush     = (lane == LAST_LANE) | in_eof;

  always_comb begin
    word_nx = in_sof ? '0 : word_q;
    for (int i = 0; i < WORD_BYTES; i++) begin
      if (lane == LANE_W'(i)) word_nx[8*i +: 8] = in_data;
      be_nx[i] = (LANE_W'(i) <= lane);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        align_en <= 1'b0;
    else if (sw_reset) align_en <= 1'b0;
    else if (cfg_we)   align_en <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q    <= '0;
      word_q    <= '0;
      cnt_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_be    <= '0;
      out_last  <= 1'b0;
      len_valid <= 1'b0;
      len_bytes <= '0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      len_valid <= 1'b0;
      if (abort) begin
        lane_q <= '0;
        word_q <= '0;
        cnt_q  <= '0;
      end else if (in_valid) begin
        word_q <= flush ? '0 : word_nx;
        lane_q <= flush ? '0 : lane + LANE_W'(1);
        cnt_q  <= cnt_nx;
        if (flush) begin
          out_valid <= 1'b1;
          out_data  <= word_nx;
          out_be    <= be_nx;
          out_last  <= in_eof;
        end
        if (in_eof) begin
          len_valid <= 1'b1;
          len_bytes <= cnt_nx;
        end
      end
    end
  end

  AST_EN_CLEARED_BY_SWRST: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_reset) |-> !cfg_rdata); // R2
  AST_STOP_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd && !sw_reset && !cfg_we |=> $stable(cfg_rdata)); // R2
  AST_FULL_WORD_BE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> &out_be); // R5
  AST_BE_LOW_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_be[0] && (((out_be + 1'b1) & out_be) == '0)); // R6
  AST_LEN_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    len_valid |-> out_valid && out_last && (len_bytes != '0)); // R7
  AST_NO_OUT_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(abort) |-> !out_valid && !len_valid); // R9
endmodule

// File: tb/test_frame_align_padder.sv
module test_frame_align_padder;
  logic clk = 0, rst_n = 0, sw_reset = 0, stop_cmd = 0, cfg_we = 0, cfg_wdata = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = 0;
  logic cfg_rdata, out_valid, out_last, len_valid;
  logic [31:0] out_data;
  logic [3:0] out_be;
  logic [15:0] len_bytes;

  frame_align_padder i_frame_align_padder (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .stop_cmd(stop_cmd),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_data(out_data), .out_be(out_be), .out_last(out_last),
    .len_valid(len_valid), .len_bytes(len_bytes));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit en_model = 0;
  logic [31:0] q_d[$], q_m[$];
  logic [3:0]  q_be[$];
  bit          q_last[$];
  string       q_tag[$];
  int          q_len[$];

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      if (q_d.size() == 0) chk(0, "R9", "unexpected word", out_data, 0);
      else begin
        logic [31:0] d, m; logic [3:0] be; bit l; string t;
        d = q_d.pop_front(); m = q_m.pop_front(); be = q_be.pop_front();
        l = q_last.pop_front(); t = q_tag.pop_front();
        chk((out_data & m) === (d & m), t, "data", out_data & m, d & m);
        chk(out_be === be, t, "byte enables", out_be, be);
        chk(out_last === l, t, "last flag", out_last, l);
      end
    end
    if (len_valid) begin
      if (q_len.size() == 0) chk(0, "R7", "unexpected length", len_bytes, 0);
      else begin
        int e; e = q_len.pop_front();
        chk(len_bytes == 16'(e), "R7", "length", len_bytes, e);
      end
    end
  end

  task automatic send_frame(input int n, input int start, input int wr_at, input bit wr_val);
    int lane; logic [31:0] d, m; bit first;
    lane = en_model ? 2 : 0; d = 0; m = 0; first = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = 8'(start + i); in_sof = (i == 0); in_eof = (i == n - 1);
      cfg_we = (i == wr_at); cfg_wdata = wr_val;
      d[8*lane +: 8] = in_data; m[8*lane +: 8] = 8'hff;
      if (lane == 3 || i == n - 1) begin
        q_d.push_back(d); q_m.push_back(m); q_be.push_back(4'((1 << (lane + 1)) - 1));
        q_last.push_back(i == n - 1);
        q_tag.push_back(first ? (en_model ? "R3" : "R4") : (i == n - 1 ? "R6" : "R5"));
        d = 0; m = 0; lane = 0; first = 0;
      end else lane++;
    end
    q_len.push_back(n);
    if (wr_at >= 0) en_model = wr_val;  // R8: new value only for later frames
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; cfg_we = 0;
  endtask

  task automatic partial_byte(input int v);
    @(negedge clk);
    in_valid = 1; in_data = 8'(v); in_sof = 1; in_eof = 0;
    @(negedge clk);
    in_valid = 0; in_sof = 0;
  endtask

  task automatic cfg_write(input bit v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
    en_model = v;
    chk(cfg_rdata === v, "R1", "enable readback", cfg_rdata, v);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid === 0 && len_valid === 0, "R1", "outputs in reset", out_valid, 0);
    chk(cfg_rdata === 0, "R1", "enable in reset", cfg_rdata, 0);
    rst_n = 1;
    idle(2);
    // R4, R5, R6, R7 unaligned
    send_frame(9, 8'h10, -1, 0);
    send_frame(4, 8'h40, -1, 0);
    idle(2);
    cfg_write(1);
    // R3 aligned frames
    send_frame(14, 8'h20, -1, 0);
    send_frame(1, 8'h70, -1, 0);
    send_frame(5, 8'h80, -1, 0);
    send_frame(64, 8'h00, -1, 0);
    idle(2);
    // R8 mid-frame write, then write on the first byte
    send_frame(10, 8'h30, 3, 0);
    chk(cfg_rdata === 0, "R8", "enable after mid-frame write", cfg_rdata, 0);
    send_frame(6, 8'h50, -1, 0);
    send_frame(7, 8'h60, 0, 1);
    send_frame(3, 8'h90, -1, 0);
    idle(2);
    // R9 and R2 stop drops partial frame, keeps enable
    partial_byte(8'hAA);
    stop_cmd = 1; @(negedge clk); stop_cmd = 0;
    chk(cfg_rdata === 1, "R2", "enable kept by stop", cfg_rdata, 1);
    send_frame(6, 8'hB0, -1, 0);
    idle(2);
    // R9 and R2 software reset drops partial frame, clears enable
    partial_byte(8'hCC);
    sw_reset = 1; @(negedge clk); sw_reset = 0;
    en_model = 0;
    chk(cfg_rdata === 0, "R2", "enable cleared by software reset", cfg_rdata, 0);
    send_frame(5, 8'hD0, -1, 0);
    idle(3);
    // R1 hardware reset clears enable
    cfg_write(1);
    rst_n = 0; @(negedge clk); rst_n = 1;
    en_model = 0;
    chk(cfg_rdata === 0, "R1", "enable after hardware reset", cfg_rdata, 0);
    idle(4);
    chk(q_d.size() == 0, "R6", "words never produced", q_d.size(), 0);
    chk(q_len.size() == 0, "R7", "lengths never produced", q_len.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule